// File: doc/BRIEF.md
# Serial Character Receiver with Per-Character Status

This block turns an asynchronous serial line into characters and queues them for a reader. It watches the line at sixteen samples per bit. It checks each start bit halfway through the bit and takes every data bit at its centre, least significant bit first. Each character is 8 or 9 bits wide. In 8-bit mode an optional even or odd parity bit may follow. Every finished character goes into a four-entry queue together with its own parity-error and framing-error tags. The error flags seen by the reader therefore always belong to the character at the head of the queue.

A reader watches the data-available flag, takes the head character and its tags, and pulses a read strobe to advance to the next entry. If a character arrives while the queue is full, an overrun flag is raised. Everything that arrives after that is thrown away until the reader clears the flag. Clearing the flag also empties the queue and restarts the receiver. In 9-bit mode an address filter can be switched on for multidrop links. It keeps only characters whose ninth bit is 1.

Top module: `rx_serial_core`

## Requirements
- R1: After reset, `avail_o`, `overrun_o`, `head_data_o`, `head_perr_o` and `head_ferr_o` are 0 and `idle_o` is 1.
- R2: A character begins with a low start bit that is still low eight ticks after it is detected. It is followed by 8 data bits (`wide_i`=0) or 9 data bits (`wide_i`=1), least significant bit first, each one sixteen `tick_i` pulses long. In 8-bit mode bit 8 of the stored data is 0.
- R3: `par_sel_i` selects the parity: 2'b01 is even and 2'b10 is odd, and in both cases one parity bit follows the data in 8-bit mode. The values 2'b00 and 2'b11 mean no parity bit. A character whose parity bit mismatches is stored with its parity tag set. In 9-bit mode no parity bit is expected and the tag is always 0.
- R4: A character whose stop-bit sample is 0 is stored with its framing tag set.
- R5: `head_perr_o` and `head_ferr_o` show the tags of the character at the head of the queue, not those of the latest one received.
- R6: `idle_o` is 0 while a character is being received and 1 otherwise.
- R7: The queue holds 4 characters in arrival order. `avail_o` is 1 whenever at least one is held. A one-cycle `rd_i` pulse removes the head entry.
- R8: A character that completes while the queue is full sets `overrun_o` and is dropped. The queue keeps its contents. While `overrun_o` is 1, every further character is dropped.
- R9: A pulse on `ovf_clr_i` while `overrun_o` is 1 clears the flag, empties the queue and returns the receiver to idle. While `overrun_o` is 0 the pulse has no effect.
- R10: With `wide_i`=1 and `addr_en_i`=1, characters whose ninth bit is 0 are dropped and characters whose ninth bit is 1 are stored.
- R11: With `wide_i`=0, `addr_en_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Sample tick, sixteen per bit time |
| wide_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| par_sel_i | input | 2 | 01 even, 10 odd, 00/11 no parity (8-bit mode only) |
| addr_en_i | input | 1 | Address filter enable (9-bit mode only) |
| rd_i | input | 1 | Read strobe: removes the head character |
| ovf_clr_i | input | 1 | Clears the overrun flag and flushes the receiver |
| head_data_o | output | 9 | Head character, 0 when the queue is empty |
| head_perr_o | output | 1 | Parity tag of the head character |
| head_ferr_o | output | 1 | Framing tag of the head character |
| avail_o | output | 1 | At least one character can be read |
| idle_o | output | 1 | Receiver is not inside a character |
| overrun_o | output | 1 | A character was lost to a full queue |

## Verification
The table-driven part sends characters in 8-bit mode with no parity, even parity and odd parity. Both good and wrong parity bits are used, along with a low stop bit. Data values with asymmetric bit patterns show whether the bit order and width are right. In 9-bit mode, characters with the ninth bit high and low are sent with the address filter on and off. This separates a filtered address character from a stored one, and shows that the filter and the parity setting are ignored in the modes where they must not apply. Directed sequences cover the following:
- the head tags when a bad character is queued ahead of a good one;
- filling the queue to its depth, to check arrival order;
- a fifth character, to raise the overrun;
- further characters sent while the overrun is held;
- a clear pulse both with and without a pending overrun.

// File: rtl/rx_serial_pkg.sv
// Shared types for the serial receiver: frame-walker states, queue entry
// layout and the parity select codes.
package rx_serial_pkg;

    localparam int CHAR_W = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_char_t;

    localparam int ENTRY_W = CHAR_W + 2;

    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;

endpackage

// File: rtl/rx_frame_sampler.sv
// Frame walker: synchronises the line, detects and checks the start bit at
// mid-bit, takes each data, parity and stop bit at its centre and emits a
// one-cycle done pulse with the finished character and its error tags.
// Assumes the tick is one clock wide and that the mode inputs stay stable
// during a character.
module rx_frame_sampler
    import rx_serial_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     flush,
    input  logic     tick,
    input  logic     line,
    input  logic     wide,
    input  logic [1:0] par_sel,
    output logic     done,
    output rx_char_t char_o,
    output logic     idle
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    rx_state_e         st;
    logic [CW-1:0]     os_cnt;
    logic [3:0]        bit_idx;
    logic [CHAR_W-1:0] shreg;
    logic              par_bit;
    logic [1:0]        sync_q;
    logic              line_s;
    logic              use_par;
    logic [3:0]        nbits;
    logic              par_ones;

    assign line_s   = sync_q[1];
    assign use_par  = !wide && (par_sel == PAR_EVEN || par_sel == PAR_ODD);
    assign nbits    = wide ? 4'd9 : 4'd8;
    assign par_ones = ^{shreg[7:0], par_bit};
    assign idle     = (st == ST_IDLE);

    // Two-flop synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], line};
    end

    // Bit-timing state machine, advanced on each sample tick.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            st      <= ST_IDLE;
            os_cnt  <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            done    <= 1'b0;
            char_o  <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (st)
                    ST_IDLE: begin
                        if (!line_s) begin
                            st     <= ST_START;
                            os_cnt <= '0;
                            shreg  <= '0;
                        end
                    end
                    ST_START: begin
                        if (os_cnt == MID) begin
                            os_cnt  <= '0;
                            bit_idx <= '0;
                            st      <= line_s ? ST_IDLE : ST_DATA;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (os_cnt == LAST) begin
                            os_cnt <= '0;
                            shreg[bit_idx] <= line_s;
                            if (bit_idx == nbits - 4'd1) st <= use_par ? ST_PAR : ST_STOP;
                            else                         bit_idx <= bit_idx + 4'd1;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (os_cnt == LAST) begin
                            os_cnt  <= '0;
                            par_bit <= line_s;
                            st      <= ST_STOP;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (os_cnt == LAST) begin
                            os_cnt      <= '0;
                            st          <= ST_IDLE;
                            done        <= 1'b1;
                            char_o.data <= shreg;
                            char_o.ferr <= !line_s;
                            char_o.perr <= use_par && ((par_sel == PAR_ODD) ? !par_ones : par_ones);
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R2
    bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA) |-> (bit_idx < nbits));

    // R6
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> idle);

endmodule

// File: rtl/rx_char_fifo.sv
// Small first-in first-out store for received characters with their tags.
// The head entry is shown combinationally. A pop on an empty store and a
// push on a full store are ignored; flush empties it in one cycle.
module rx_char_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] PMAX = AW'(DEPTH - 1);
    localparam logic [AW:0]   CMAX = (AW + 1)'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CMAX);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage array write port.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PMAX) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PMAX) ? '0 : rd_ptr + 1'b1;
            count <= count + (do_push ? 1'b1 : 1'b0) - (do_pop ? 1'b1 : 1'b0);
        end
    end

    // R7
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R7
    fifo_fill_chk: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (push && !pop) |=> !empty);

endmodule

// File: rtl/rx_serial_core.sv
// Serial receiver top: joins the frame walker and the character queue,
// applies the address filter and the overrun rules, and presents the head
// character with its tags plus the status flags. Assumes rd_i and ovf_clr_i
// are single-cycle pulses.
module rx_serial_core
    import rx_serial_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    input  logic              tick_i,
    input  logic              wide_i,
    input  logic [1:0]        par_sel_i,
    input  logic              addr_en_i,
    input  logic              rd_i,
    input  logic              ovf_clr_i,
    output logic [CHAR_W-1:0] head_data_o,
    output logic              head_perr_o,
    output logic              head_ferr_o,
    output logic              avail_o,
    output logic              idle_o,
    output logic              overrun_o
);
    rx_char_t rx_char, head;
    logic     rx_done, q_empty, q_full;
    logic     clr_hit, addr_drop, accept, push, overrun_q;

    assign clr_hit   = ovf_clr_i && overrun_q;
    assign addr_drop = wide_i && addr_en_i && !rx_char.data[CHAR_W-1];
    assign accept    = rx_done && !overrun_q && !addr_drop;
    assign push      = accept && !q_full;

    rx_frame_sampler #(.OSR(OSR)) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (clr_hit),
        .tick    (tick_i),
        .line    (line_i),
        .wide    (wide_i),
        .par_sel (par_sel_i),
        .done    (rx_done),
        .char_o  (rx_char),
        .idle    (idle_o)
    );

    rx_char_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (clr_hit),
        .push  (push),
        .din   (rx_char),
        .pop   (rd_i),
        .dout  (head),
        .empty (q_empty),
        .full  (q_full)
    );

    // Overrun flag: set by a character landing on a full queue, cleared only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)               overrun_q <= 1'b0;
        else if (clr_hit)         overrun_q <= 1'b0;
        else if (accept && q_full) overrun_q <= 1'b1;
    end

    assign overrun_o   = overrun_q;
    assign avail_o     = !q_empty;
    assign head_data_o = q_empty ? '0 : head.data;
    assign head_perr_o = !q_empty && head.perr;
    assign head_ferr_o = !q_empty && head.ferr;

    // R8
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_q) |-> $past(rx_done && q_full));

    // R9
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> (!overrun_o && !avail_o));

    // R10
    addr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && addr_drop && !rd_i && !clr_hit) |=> $stable(q_empty));

endmodule

// File: tb/rx_serial_core_test.sv
`timescale 1ns/1ps
module rx_serial_core_test;

    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;

    typedef struct packed {
        logic       wide;
        logic [1:0] par;
        logic       aen;
        logic [8:0] d;
        logic       badp;
        logic       bads;
        logic       stored;
        logic [8:0] exp_d;
        logic       exp_perr;
        logic       exp_ferr;
    } vec_t;

    // wide, par, aen, data, bad parity, bad stop, stored, expected data, perr, ferr
    localparam vec_t VECS [10] = '{
        '{1'b0, 2'd0, 1'b0, 9'h0A5, 1'b0, 1'b0, 1'b1, 9'h0A5, 1'b0, 1'b0},  // R2
        '{1'b0, 2'd1, 1'b0, 9'h03C, 1'b0, 1'b0, 1'b1, 9'h03C, 1'b0, 1'b0},  // R3 even ok
        '{1'b0, 2'd1, 1'b0, 9'h03C, 1'b1, 1'b0, 1'b1, 9'h03C, 1'b1, 1'b0},  // R3 even bad
        '{1'b0, 2'd2, 1'b0, 9'h081, 1'b0, 1'b0, 1'b1, 9'h081, 1'b0, 1'b0},  // R3 odd ok
        '{1'b0, 2'd2, 1'b0, 9'h000, 1'b1, 1'b0, 1'b1, 9'h000, 1'b1, 1'b0},  // R3 odd bad
        '{1'b0, 2'd0, 1'b0, 9'h055, 1'b0, 1'b1, 1'b1, 9'h055, 1'b0, 1'b1},  // R4
        '{1'b1, 2'd1, 1'b0, 9'h1F0, 1'b0, 1'b0, 1'b1, 9'h1F0, 1'b0, 1'b0},  // R2 9-bit, R3 no parity
        '{1'b1, 2'd0, 1'b1, 9'h0F0, 1'b0, 1'b0, 1'b0, 9'h000, 1'b0, 1'b0},  // R10 dropped
        '{1'b1, 2'd0, 1'b1, 9'h142, 1'b0, 1'b0, 1'b1, 9'h142, 1'b0, 1'b0},  // R10 kept
        '{1'b0, 2'd0, 1'b1, 9'h007, 1'b0, 1'b0, 1'b1, 9'h007, 1'b0, 1'b0}   // R11
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_i = 1'b1;
    logic       tick_i = 1'b0;
    logic       wide_i = 1'b0;
    logic [1:0] par_sel_i = 2'd0;
    logic       addr_en_i = 1'b0;
    logic       rd_i = 1'b0;
    logic       ovf_clr_i = 1'b0;
    logic [8:0] head_data_o;
    logic       head_perr_o, head_ferr_o, avail_o, idle_o, overrun_o;

    int tests = 0;
    int fails = 0;
    bit done_flag = 1'b0;
    int tick_cnt = 0;

    always #2.5 clk = ~clk;

    rx_serial_core uut (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .tick_i(tick_i),
        .wide_i(wide_i), .par_sel_i(par_sel_i), .addr_en_i(addr_en_i),
        .rd_i(rd_i), .ovf_clr_i(ovf_clr_i), .head_data_o(head_data_o),
        .head_perr_o(head_perr_o), .head_ferr_o(head_ferr_o),
        .avail_o(avail_o), .idle_o(idle_o), .overrun_o(overrun_o)
    );

    // Free-running sample tick, one clock wide every TICK_DIV clocks.
    always @(posedge clk) begin
        tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
        tick_i   <= (tick_cnt == TICK_DIV - 1);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        line_i = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] d, input logic badp, input logic stop_v,
                        output logic mid_idle);
        logic p;
        int nb;
        nb = wide_i ? 9 : 8;
        mid_idle = 1'b1;
        hold_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            hold_bit(d[i]);
            if (i == 2) mid_idle = idle_o;
        end
        if (!wide_i && (par_sel_i == 2'd1 || par_sel_i == 2'd2)) begin
            p = (par_sel_i == 2'd1) ? ^d[7:0] : ~^d[7:0];
            if (badp) p = ~p;
            hold_bit(p);
        end
        hold_bit(stop_v);
        line_i = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_ok(input logic [8:0] d);
        logic mi;
        send(d, 1'b0, 1'b1, mi);
    endtask

    task automatic pulse_rd();
        rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        ovf_clr_i = 1'b1;
        @(negedge clk);
        ovf_clr_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic mi;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1 avail", avail_o, 1'b0);
        check("R1 overrun", overrun_o, 1'b0);
        check("R1 idle", idle_o, 1'b1);
        check("R1 head data", head_data_o, 9'h000);
        check("R1 head tags", {head_perr_o, head_ferr_o}, 2'b00);

        // Table walk: one character per vector.
        for (int k = 0; k < 10; k++) begin
            wide_i    = VECS[k].wide;
            par_sel_i = VECS[k].par;
            addr_en_i = VECS[k].aen;
            @(negedge clk);
            send(VECS[k].d, VECS[k].badp, !VECS[k].bads, mi);
            check("R6 idle low mid-character", mi, 1'b0);
            check("R6 idle high after character", idle_o, 1'b1);
            check("R7/R10 stored", avail_o, VECS[k].stored);
            if (VECS[k].stored) begin
                check("R2/R11 data", head_data_o, VECS[k].exp_d);
                check("R3 parity tag", head_perr_o, VECS[k].exp_perr);
                check("R4 framing tag", head_ferr_o, VECS[k].exp_ferr);
                pulse_rd();
                check("R7 empty after read", avail_o, 1'b0);
            end
        end

        // R5: tags follow the head, not the newest character.
        wide_i = 1'b0; par_sel_i = 2'd1; addr_en_i = 1'b0;
        send(9'h011, 1'b1, 1'b1, mi);
        send(9'h022, 1'b0, 1'b1, mi);
        check("R5 head data first", head_data_o, 9'h011);
        check("R5 head perr first", head_perr_o, 1'b1);
        pulse_rd();
        check("R5 head data second", head_data_o, 9'h022);
        check("R5 head perr second", head_perr_o, 1'b0);
        pulse_rd();

        // R7, R8: fill, overflow, drop while overrun, order kept.
        par_sel_i = 2'd0;
        for (int i = 1; i <= 4; i++) send_ok(9'(i));
        check("R8 no overrun at depth", overrun_o, 1'b0);
        pulse_clr();
        check("R9 clear ignored when flag low: avail", avail_o, 1'b1);
        check("R9 clear ignored when flag low: head", head_data_o, 9'h001);
        send_ok(9'h005);
        check("R8 overrun set", overrun_o, 1'b1);
        check("R8 head unchanged", head_data_o, 9'h001);
        pulse_rd();
        check("R7 order 2", head_data_o, 9'h002);
        send_ok(9'h006);
        pulse_rd();
        check("R7 order 3", head_data_o, 9'h003);
        pulse_rd();
        check("R7 order 4", head_data_o, 9'h004);
        pulse_rd();
        check("R8 drop while overrun", avail_o, 1'b0);
        check("R8 overrun held", overrun_o, 1'b1);

        // R9: clearing with a full queue flushes it.
        pulse_clr();
        for (int i = 1; i <= 5; i++) send_ok(9'(8'h40 + i));
        check("R8 overrun again", overrun_o, 1'b1);
        pulse_clr();
        check("R9 overrun cleared", overrun_o, 1'b0);
        check("R9 queue flushed", avail_o, 1'b0);
        check("R9 idle after clear", idle_o, 1'b1);
        send_ok(9'h09A);
        check("R9 receives after clear", head_data_o, 9'h09A);
        check("R9 avail after clear", avail_o, 1'b1);

        finish_run();
    end

endmodule